// File: doc/BRIEF.md
# Gated Store Buffer with Commit and Rollback

This block holds memory stores issued by speculatively executed code until an outside controller declares them final. Each store carries an address, a data word and per-byte enables, and it enters the queue as uncommitted. A commit command turns every entry present at that moment into a committed entry. A rollback command removes every entry that is still uncommitted, so those stores never reach memory. Only committed entries leave the queue. They go out oldest first, one per cycle, through a valid/ready write port.

Loads can probe the queue for store-to-load forwarding. The probe looks for the youngest entry whose address matches, whether that entry is committed or not. It returns a hit only if that entry's byte enables include every byte the load asks for. The probe result is registered, so it appears one cycle after the probe and reflects the queue contents of the probe cycle. The depth must be a power of two.

Top module: `shb_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the queue is empty, and `st_stall`, `mem_valid` and `ld_hit` are low.
- R2: A store is accepted at a rising edge where `st_valid` is high, `st_stall` is low and `cmd_rollback` is low. It is appended behind all present entries as uncommitted.
- R3: `cmd_commit` marks all entries present before the edge as committed, in one cycle. A store accepted in the same cycle stays uncommitted.
- R4: `mem_valid` is high exactly when at least one committed entry is held. Uncommitted entries are never presented on the write port.
- R5: Committed entries leave in arrival order, one per edge where `mem_valid` and `mem_ready` are both high. `mem_addr`, `mem_data` and `mem_be` show the oldest entry and hold steady while `mem_ready` is low.
- R6: `st_stall` is high exactly when DEPTH entries are held. A store offered while `st_stall` is high is dropped.
- R7: `cmd_rollback` discards every uncommitted entry in one cycle and keeps the committed ones. A store in the same cycle is also discarded. Rollback overrides a commit in the same cycle.
- R8: A probe (`ld_addr`, `ld_be`) selects the youngest held entry whose address equals `ld_addr`. On the next cycle `ld_hit` is 1 if that entry's enables include all bits of `ld_be`, where enable bit i covers data bits 8i+7..8i. On a hit, `ld_data` holds the entry's data with the unrequested bytes forced to zero. Without a hit, `ld_data` is zero.
- R9: If the youngest matching entry does not cover the requested bytes, the result is no hit, even when an older matching entry would cover them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_stall | output | 1 | Queue full; stores are refused |
| cmd_commit | input | 1 | Commit all present entries |
| cmd_rollback | input | 1 | Discard all uncommitted entries |
| mem_valid | output | 1 | Oldest committed entry is available |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Write address |
| mem_data | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables |
| ld_addr | input | AW | Probe address |
| ld_be | input | DW/8 | Probe requested bytes |
| ld_hit | output | 1 | Registered forwarding hit |
| ld_data | output | DW | Registered forwarded data, masked |

## Verification
The bench builds the block with DEPTH set to 4 and 32-bit address and data. The shallow queue fills often under random traffic, so the stall path, pointer wrap-around and a rollback on a full queue all occur many times. Store addresses are drawn from a pool of four words. This makes address matches among committed and uncommitted entries common, and it forces the case where the youngest match only partly covers the requested bytes.

// File: rtl/shb_pkg.sv
package shb_pkg;

  // Resolved control action for one cycle
  typedef enum logic [1:0] {
    CTL_NONE     = 2'd0,
    CTL_COMMIT   = 2'd1,
    CTL_ROLLBACK = 2'd2
  } shb_ctl_e;

  // Rollback takes precedence over commit
  function automatic shb_ctl_e shb_resolve(input logic commit, input logic rollback);
    if (rollback) return CTL_ROLLBACK;
    if (commit)   return CTL_COMMIT;
    return CTL_NONE;
  endfunction

endpackage

// File: rtl/shb_ctrl.sv
module shb_ctrl
  import shb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  shb_ctl_e      ctl,
  input  logic          mem_ready,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx,
  output logic [PW:0]   occ,
  output logic          stall,
  output logic          mem_valid
);

  // head: oldest entry, bound: first uncommitted entry, tail: next free slot
  logic [PW:0] head_q, bound_q, tail_q;
  logic        drain;

  assign occ       = tail_q - head_q;
  assign stall     = (occ == (PW+1)'(DEPTH));
  assign mem_valid = (bound_q != head_q);
  assign drain     = mem_valid && mem_ready;
  assign wr_en     = st_valid && !stall && (ctl != CTL_ROLLBACK);
  assign wr_idx    = tail_q[PW-1:0];
  assign rd_idx    = head_q[PW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      bound_q <= '0;
      tail_q  <= '0;
    end else begin
      if (drain) head_q <= head_q + 1'b1;
      unique case (ctl)
        CTL_ROLLBACK: tail_q <= bound_q;
        CTL_COMMIT: begin
          bound_q <= tail_q;
          tail_q  <= tail_q + (PW+1)'(wr_en);
        end
        default: tail_q <= tail_q + (PW+1)'(wr_en);
      endcase
    end
  end

endmodule

// File: rtl/shb_store.sv
module shb_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BEW  = DW / 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [PW-1:0]              wr_idx,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [BEW-1:0]             wr_be,
  input  logic [PW-1:0]              rd_idx,
  output logic [AW-1:0]              rd_addr,
  output logic [DW-1:0]              rd_data,
  output logic [BEW-1:0]             rd_be,
  output logic [DEPTH-1:0][AW-1:0]   all_addr,
  output logic [DEPTH-1:0][DW-1:0]   all_data,
  output logic [DEPTH-1:0][BEW-1:0]  all_be
);

  logic [DEPTH-1:0][AW-1:0]  addr_q;
  logic [DEPTH-1:0][DW-1:0]  data_q;
  logic [DEPTH-1:0][BEW-1:0] be_q;

  // No reset: contents are only read inside the occupied window
  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_idx] <= wr_addr;
      data_q[wr_idx] <= wr_data;
      be_q[wr_idx]   <= wr_be;
    end
  end

  assign rd_addr  = addr_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
  assign rd_be    = be_q[rd_idx];
  assign all_addr = addr_q;
  assign all_data = data_q;
  assign all_be   = be_q;

endmodule

// File: rtl/shb_fwd.sv
module shb_fwd #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BEW  = DW / 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
  input  logic [DEPTH-1:0][DW-1:0]   ent_data,
  input  logic [DEPTH-1:0][BEW-1:0]  ent_be,
  input  logic [PW-1:0]              base_idx,
  input  logic [PW:0]                occ,
  input  logic [AW-1:0]              ld_addr,
  input  logic [BEW-1:0]             ld_be,
  output logic                       ld_hit,
  output logic [DW-1:0]              ld_data
);

  logic           found;
  logic [BEW-1:0] sel_be;
  logic [DW-1:0]  sel_data;
  logic [PW-1:0]  idx;
  logic [DW-1:0]  mask;
  logic           hit_c;

  for (genvar b = 0; b < BEW; b++) begin : g_mask
    assign mask[8*b +: 8] = {8{ld_be[b]}};
  end

  // Walk oldest to youngest; the last match wins
  always_comb begin
    found    = 1'b0;
    sel_be   = '0;
    sel_data = '0;
    idx      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = base_idx + k[PW-1:0];
      if ((k < int'(occ)) && (ent_addr[idx] == ld_addr)) begin
        found    = 1'b1;
        sel_be   = ent_be[idx];
        sel_data = ent_data[idx];
      end
    end
  end

  assign hit_c = found && ((sel_be & ld_be) == ld_be);

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit  <= 1'b0;
      ld_data <= '0;
    end else begin
      ld_hit  <= hit_c;
      ld_data <= hit_c ? (sel_data & mask) : '0;
    end
  end

endmodule

// File: rtl/shb_top.sv
module shb_top
  import shb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BEW  = DW / 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           st_valid,
  input  logic [AW-1:0]  st_addr,
  input  logic [DW-1:0]  st_data,
  input  logic [BEW-1:0] st_be,
  output logic           st_stall,
  input  logic           cmd_commit,
  input  logic           cmd_rollback,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic [BEW-1:0] mem_be,
  input  logic [AW-1:0]  ld_addr,
  input  logic [BEW-1:0] ld_be,
  output logic           ld_hit,
  output logic [DW-1:0]  ld_data
);

  shb_ctl_e                  ctl;
  logic                      wr_en;
  logic [PW-1:0]             wr_idx, rd_idx;
  logic [PW:0]               occ;
  logic [DEPTH-1:0][AW-1:0]  all_addr;
  logic [DEPTH-1:0][DW-1:0]  all_data;
  logic [DEPTH-1:0][BEW-1:0] all_be;

  assign ctl = shb_resolve(cmd_commit, cmd_rollback);

  shb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .ctl       (ctl),
    .mem_ready (mem_ready),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .occ       (occ),
    .stall     (st_stall),
    .mem_valid (mem_valid)
  );

  shb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_addr  (st_addr),
    .wr_data  (st_data),
    .wr_be    (st_be),
    .rd_idx   (rd_idx),
    .rd_addr  (mem_addr),
    .rd_data  (mem_data),
    .rd_be    (mem_be),
    .all_addr (all_addr),
    .all_data (all_data),
    .all_be   (all_be)
  );

  shb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .clk      (clk),
    .rst      (rst),
    .ent_addr (all_addr),
    .ent_data (all_data),
    .ent_be   (all_be),
    .base_idx (rd_idx),
    .occ      (occ),
    .ld_addr  (ld_addr),
    .ld_be    (ld_be),
    .ld_hit   (ld_hit),
    .ld_data  (ld_data)
  );

endmodule

// File: rtl/shb_chk.sv
module shb_chk #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int BEW = DW / 8
) (
  input logic           clk,
  input logic           rst,
  input logic           st_stall,
  input logic           cmd_commit,
  input logic           cmd_rollback,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_data,
  input logic [BEW-1:0] mem_be,
  input logic [BEW-1:0] ld_be,
  input logic           ld_hit,
  input logic [DW-1:0]  ld_data
);

  logic [DW-1:0] ld_mask;
  for (genvar b = 0; b < BEW; b++) begin : g_m
    assign ld_mask[8*b +: 8] = {8{ld_be[b]}};
  end

  // R1
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (!mem_valid && !st_stall && !ld_hit));

  // R4
  a_r4_no_commit_no_drain: assert property (@(posedge clk) disable iff (rst)
    (!mem_valid && !cmd_commit) |=> !mem_valid);

  // R5
  a_r5_hold_when_blocked: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

  // R6
  a_r6_stall_persists: assert property (@(posedge clk) disable iff (rst)
    (st_stall && !(mem_valid && mem_ready) && !cmd_rollback) |=> st_stall);

  // R7
  a_r7_rollback_adds_nothing: assert property (@(posedge clk) disable iff (rst)
    (cmd_rollback && !mem_valid) |=> !mem_valid);

  // R8
  a_r8_miss_data_zero: assert property (@(posedge clk) disable iff (rst)
    !ld_hit |-> (ld_data == '0));

  // R8
  a_r8_hit_masked: assert property (@(posedge clk) disable iff (rst)
    ld_hit |-> ((ld_data & ~$past(ld_mask)) == '0));

endmodule

bind shb_top shb_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_shb_top.sv
module sim_shb_top;

  localparam int BD = 4;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  b;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic        st_stall;
  logic        cmd_commit = 1'b0;
  logic        cmd_rollback = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_be;
  logic [31:0] ld_addr = '0;
  logic [3:0]  ld_be = '0;
  logic        ld_hit;
  logic [31:0] ld_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  ent_t q[$];
  int   ncmt = 0;
  logic        exp_hit = 1'b0;
  logic [31:0] exp_data = '0;
  string       exp_tag = "R8";

  always #2.5 clk = ~clk;

  shb_top #(.DEPTH(BD), .AW(32), .DW(32)) u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expand(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // One cycle: called at a falling edge, returns at the next falling edge
  task automatic cycle(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                       input logic [3:0] sb, input logic cm, input logic rb,
                       input logic rdy, input logic [31:0] la, input logic [3:0] lb);
    logic drain;
    int   youngest;
    // outputs against model
    chk("R6", "st_stall", 32'(st_stall), 32'(q.size() == BD));
    chk("R4", "mem_valid", 32'(mem_valid), 32'(ncmt > 0));
    if (ncmt > 0) begin
      chk("R5", "mem_addr", mem_addr, q[0].a);
      chk("R5", "mem_data", mem_data, q[0].d);
      chk("R5", "mem_be", 32'(mem_be), 32'(q[0].b));
    end
    chk(exp_tag, "ld_hit", 32'(ld_hit), 32'(exp_hit));
    chk(exp_tag, "ld_data", ld_data, exp_data);
    // drive
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    cmd_commit = cm; cmd_rollback = rb; mem_ready = rdy;
    ld_addr = la; ld_be = lb;
    // expected probe result from current contents
    exp_hit = 1'b0; exp_data = '0; exp_tag = "R8"; youngest = -1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].a == la) begin youngest = i; break; end
    end
    if (youngest >= 0) begin
      if ((q[youngest].b & lb) == lb) begin
        exp_hit = 1'b1;
        exp_data = q[youngest].d & expand(lb);
      end else begin
        for (int i = 0; i < youngest; i++)
          if (q[i].a == la && (q[i].b & lb) == lb) exp_tag = "R9";
      end
    end
    // model update from pre-edge state
    drain = (ncmt > 0) && rdy;
    if (rb) begin
      while (q.size() > ncmt) void'(q.pop_back());
    end else begin
      if (cm) ncmt = q.size();
      if (sv && q.size() < BD) q.push_back('{a: sa, d: sd, b: sb});
    end
    if (drain) begin
      void'(q.pop_front());
      ncmt--;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic rdy);
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b0, rdy, 32'hFFFF_0000, 4'hF);
  endtask

  initial begin
    int n;
    n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset
    chk("R1", "st_stall", 32'(st_stall), 32'd0);
    chk("R1", "mem_valid", 32'(mem_valid), 32'd0);
    chk("R1", "ld_hit", 32'(ld_hit), 32'd0);

    // R2 R4: uncommitted stores stay inside, even with memory ready
    cycle(1, 32'h100, 32'hAAAA_0001, 4'hF, 0, 0, 1, 32'h0, 4'hF);
    cycle(1, 32'h104, 32'hAAAA_0002, 4'h3, 0, 0, 1, 32'h0, 4'hF);
    cycle(0, 0, 0, 0, 0, 0, 1, 32'h100, 4'h6);   // R8 forward from uncommitted
    idle(1);
    // R3: commit together with a store; new store stays uncommitted
    cycle(1, 32'h108, 32'hAAAA_0003, 4'hF, 1, 0, 0, 32'h104, 4'h3);
    idle(0);
    idle(1);
    idle(1);
    idle(1);
    // R7: rollback with a store drops both
    cycle(1, 32'h10C, 32'hAAAA_0004, 4'hF, 0, 1, 0, 32'h108, 4'hF);
    idle(1);
    // R6: fill to full, then an extra store is refused
    for (int i = 0; i < BD + 2; i++)
      cycle(1, 32'h200 + 32'(4*i), 32'hB000_0000 + 32'(i), 4'hF, 0, 0, 0, 32'h200, 4'hF);
    cycle(0, 0, 0, 0, 1, 0, 0, 32'h204, 4'hF);
    for (int i = 0; i < BD + 1; i++) idle(1);
    // R9: youngest match covers only part of the request
    cycle(1, 32'h300, 32'hC0C0_C0C0, 4'hF, 0, 0, 0, 0, 4'hF);
    cycle(1, 32'h300, 32'hD1D1_D1D1, 4'h3, 0, 0, 0, 0, 4'hF);
    cycle(0, 0, 0, 0, 0, 0, 0, 32'h300, 4'hF);
    cycle(0, 0, 0, 0, 0, 0, 0, 32'h300, 4'h1);
    // R7: rollback overrides a commit in the same cycle
    cycle(0, 0, 0, 0, 1, 1, 1, 32'h300, 4'h3);
    idle(1);
    idle(1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, la;
      a  = 32'h100 + 32'($urandom_range(0, 3) * 4);
      la = 32'h100 + 32'($urandom_range(0, 3) * 4);
      cycle(($urandom_range(0, 99) < 60), a, $urandom(), 4'($urandom_range(1, 15)),
            ($urandom_range(0, 99) < 15), ($urandom_range(0, 99) < 6),
            ($urandom_range(0, 99) < 55), la, 4'($urandom_range(1, 15)));
    end
    for (int i = 0; i < BD + 2; i++) idle(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule